// File: doc/BRIEF.md
# Graphics Request Intake Queue with Locked Source Selection

This block sits at the target side of a graphics bus and collects the address/command requests that the bus master issues. There are two ways in. On the strobe path, the master holds an active-low strobe and presents one full-width address per clock. On the sideband path, the master sends the address as a series of 8-bit transfers on a narrow bus, and the block joins them into one full-width word. Either path writes into a single first-in first-out queue. Downstream logic drains that queue through a show-ahead read port.

Only one path may ever be in use. Configuration picks it with a single register write after reset, and that choice then holds until the next reset. Until the write happens, no path is open and nothing is queued. In the low-swing signalling mode the strobe path is forbidden, so a request to select it in that mode is refused. Traffic on a path that is not selected never reaches the queue and raises a sticky protocol-error flag. A push into a full queue is dropped and raises a sticky overflow flag.

Top module: `gfx_req_intake`

## Requirements
- R1: After reset, `activeMode` is 0 (no path), `modeLocked` is 0, the queue is empty and `protoErr`, `overflow` and `cfgErr` are all 0. While no path is selected, strobe or sideband activity pushes nothing and sets `protoErr`.
- R2: A write with `cfgWrEn` high while unlocked, carrying `cfgMode` = 1 (strobe path) or 2 (sideband path), shows in `activeMode` and sets `modeLocked` at the next clock edge. A write with code 0 or 3 is refused: `cfgErr` is set and the block stays unlocked.
- R3: A write of code 1 while `cfgLowSwing` is 1 is refused: `cfgErr` is set and `activeMode` stays 0.
- R4: Once `modeLocked` is 1, any further configuration write is ignored, `activeMode` keeps its value and `cfgErr` is set.
- R5: In strobe mode, every rising edge at which `pipeN` is 0 pushes the value of `addrBus` at that edge, which is exactly one entry per cycle. An edge with `pipeN` at 1 pushes nothing.
- R6: In sideband mode, `pipeN` low pushes nothing and sets `protoErr`.
- R7: In sideband mode, each edge with `sbValid` high takes one byte. ADDR_W/8 bytes make one entry, and the first byte goes into bits 7:0, the next into bits 15:8 and so on. Bytes need not come in back-to-back cycles, and the entry is pushed at the edge of its last byte.
- R8: In strobe mode, `sbValid` high pushes nothing, does not advance the byte assembly, and sets `protoErr`.
- R9: `popData` shows the oldest entry whenever `fifoEmpty` is 0. `popEn` at an edge removes that entry. `popEn` on an empty queue has no effect. Entries leave in the order they were pushed.
- R10: A push at an edge where the queue already holds FIFO_DEPTH entries is dropped, even if a pop happens at the same edge. It sets `overflow`, and the entries already stored are unchanged.
- R11: `protoErr`, `overflow` and `cfgErr` are sticky and clear only on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgMode | input | 2 | Path code written: 1 strobe, 2 sideband |
| cfgLowSwing | input | 1 | Low-swing signalling active during the write |
| pipeN | input | 1 | Active-low strobe qualifying `addrBus` |
| addrBus | input | ADDR_W | Full-width request address |
| sbValid | input | 1 | Sideband byte valid |
| sbData | input | 8 | Sideband byte |
| popEn | input | 1 | Remove the head entry |
| popData | output | ADDR_W | Head entry of the queue |
| fifoEmpty | output | 1 | Queue holds no entry |
| fifoFull | output | 1 | Queue holds FIFO_DEPTH entries |
| activeMode | output | 2 | Selected path: 0 none, 1 strobe, 2 sideband |
| modeLocked | output | 1 | Path choice has been taken |
| protoErr | output | 1 | Sticky: activity on an unselected path |
| overflow | output | 1 | Sticky: push dropped on a full queue |
| cfgErr | output | 1 | Sticky: refused or late configuration write |

## Verification
The bench tries to re-select the path after the lock, selects the strobe path under low swing, and writes the reserved codes. A design that let the mode change would start taking entries from the wrong bus, and one that honoured the low-swing request would open a forbidden path. It sends traffic on the unselected path in each mode and before any selection. A leaky design would grow the queue or corrupt a half-assembled sideband word. It feeds sideband bytes with gaps and pops at the same time. A wrong byte order or a miscounted assembly would show up as swapped bytes or entries pushed early. It also fills the queue past its depth, including a push and pop at the same full edge, to catch designs that overwrite the oldest entry or accept the push.

// File: rtl/gri_pkg.sv
package gri_pkg;

  typedef enum logic [1:0] {
    MODE_NONE     = 2'd0,
    MODE_STROBE   = 2'd1,
    MODE_SIDEBAND = 2'd2,
    MODE_RSVD     = 2'd3
  } reqMode_e;

  // Strobes from control to datapath, valid for the current cycle
  typedef struct packed {
    logic pushReq;     // write one entry into the queue
    logic pushFromSb;  // the entry comes from the sideband assembler
    logic sbLoad;      // store the sideband byte into the assembler
    logic popReq;      // drop the head entry
  } dpCtl_t;

endpackage

// File: rtl/gri_ctrl.sv
module gri_ctrl
  import gri_pkg::*;
#(
  parameter int BYTES = 4,
  parameter int IDXW  = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWrEn,
  input  logic [1:0]      cfgMode,
  input  logic            cfgLowSwing,
  input  logic            pipeN,
  input  logic            sbValid,
  input  logic            popEn,
  input  logic            fifoFull,
  input  logic            fifoEmpty,
  output dpCtl_t          dpCtl,
  output logic [IDXW-1:0] byteIdx,
  output logic [1:0]      activeMode,
  output logic            modeLocked,
  output logic            protoErr,
  output logic            overflow,
  output logic            cfgErr
);

  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(BYTES - 1);

  reqMode_e        modeQ;
  logic            lockedQ;
  logic [IDXW-1:0] byteIdxQ;
  logic            protoErrQ, overflowQ, cfgErrQ;

  logic strobeHit, sbHit, sbLast, wantPush, cfgOk, misuse;
  reqMode_e cfgReq;

  always_comb begin
    cfgReq    = reqMode_e'(cfgMode);
    strobeHit = !pipeN && (modeQ == MODE_STROBE);
    sbHit     = sbValid && (modeQ == MODE_SIDEBAND);
    sbLast    = sbHit && (byteIdxQ == LAST_IDX);
    wantPush  = strobeHit || sbLast;
    cfgOk     = !lockedQ &&
                ((cfgReq == MODE_SIDEBAND) ||
                 ((cfgReq == MODE_STROBE) && !cfgLowSwing));
    misuse    = (!pipeN && (modeQ != MODE_STROBE)) ||
                (sbValid && (modeQ != MODE_SIDEBAND));

    dpCtl.pushReq    = wantPush && !fifoFull;
    dpCtl.pushFromSb = sbLast;
    dpCtl.sbLoad     = sbHit;
    dpCtl.popReq     = popEn && !fifoEmpty;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ     <= MODE_NONE;
      lockedQ   <= 1'b0;
      byteIdxQ  <= '0;
      protoErrQ <= 1'b0;
      overflowQ <= 1'b0;
      cfgErrQ   <= 1'b0;
    end else begin
      if (cfgWrEn) begin
        if (cfgOk) begin
          modeQ   <= cfgReq;
          lockedQ <= 1'b1;
        end else begin
          cfgErrQ <= 1'b1;
        end
      end
      if (misuse)               protoErrQ <= 1'b1;
      if (wantPush && fifoFull) overflowQ <= 1'b1;
      if (sbHit) byteIdxQ <= sbLast ? '0 : byteIdxQ + 1'b1;
    end
  end

  assign byteIdx    = byteIdxQ;
  assign activeMode = modeQ;
  assign modeLocked = lockedQ;
  assign protoErr   = protoErrQ;
  assign overflow   = overflowQ;
  assign cfgErr     = cfgErrQ;

endmodule

// File: rtl/gri_datapath.sv
module gri_datapath
  import gri_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  parameter int IDXW   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [IDXW-1:0]   byteIdx,
  input  logic [ADDR_W-1:0] addrBus,
  input  logic [7:0]        sbData,
  output logic [ADDR_W-1:0] popData,
  output logic              fifoFull,
  output logic              fifoEmpty
);

  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [PTRW-1:0] PTR_LAST = PTRW'(DEPTH - 1);
  localparam logic [CNTW-1:0] CNT_FULL = CNTW'(DEPTH);

  logic [ADDR_W-1:0] store [DEPTH];
  logic [ADDR_W-1:0] sbAsm, sbWord, pushData;
  logic [PTRW-1:0]   wrPtr, rdPtr;
  logic [CNTW-1:0]   count;

  function automatic logic [PTRW-1:0] ptrNext(input logic [PTRW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  // Last byte joins the partial word in the same cycle
  always_comb begin
    sbWord = sbAsm;
    sbWord[int'(byteIdx) * 8 +: 8] = sbData;
    pushData = dpCtl.pushFromSb ? sbWord : addrBus;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             sbAsm <= '0;
    else if (dpCtl.sbLoad) sbAsm[int'(byteIdx) * 8 +: 8] <= sbData;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        store[e] <= '0;
      else if (dpCtl.pushReq && (wrPtr == PTRW'(e)))
        store[e] <= pushData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (dpCtl.pushReq) wrPtr <= ptrNext(wrPtr);
      if (dpCtl.popReq)  rdPtr <= ptrNext(rdPtr);
      case ({dpCtl.pushReq, dpCtl.popReq})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign popData   = store[rdPtr];
  assign fifoFull  = (count == CNT_FULL);
  assign fifoEmpty = (count == '0);

endmodule

// File: rtl/gfx_req_intake.sv
module gfx_req_intake
  import gri_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgMode,
  input  logic              cfgLowSwing,
  input  logic              pipeN,
  input  logic [ADDR_W-1:0] addrBus,
  input  logic              sbValid,
  input  logic [7:0]        sbData,
  input  logic              popEn,
  output logic [ADDR_W-1:0] popData,
  output logic              fifoEmpty,
  output logic              fifoFull,
  output logic [1:0]        activeMode,
  output logic              modeLocked,
  output logic              protoErr,
  output logic              overflow,
  output logic              cfgErr
);

  localparam int BYTES = ADDR_W / 8;
  localparam int IDXW  = (BYTES > 1) ? $clog2(BYTES) : 1;

  dpCtl_t          dpCtl;
  logic [IDXW-1:0] byteIdx;

  gri_ctrl #(.BYTES(BYTES), .IDXW(IDXW)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWrEn     (cfgWrEn),
    .cfgMode     (cfgMode),
    .cfgLowSwing (cfgLowSwing),
    .pipeN       (pipeN),
    .sbValid     (sbValid),
    .popEn       (popEn),
    .fifoFull    (fifoFull),
    .fifoEmpty   (fifoEmpty),
    .dpCtl       (dpCtl),
    .byteIdx     (byteIdx),
    .activeMode  (activeMode),
    .modeLocked  (modeLocked),
    .protoErr    (protoErr),
    .overflow    (overflow),
    .cfgErr      (cfgErr)
  );

  gri_datapath #(.ADDR_W(ADDR_W), .DEPTH(FIFO_DEPTH), .IDXW(IDXW)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .dpCtl     (dpCtl),
    .byteIdx   (byteIdx),
    .addrBus   (addrBus),
    .sbData    (sbData),
    .popData   (popData),
    .fifoFull  (fifoFull),
    .fifoEmpty (fifoEmpty)
  );

endmodule

// File: rtl/gri_checker.sv
module gri_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cfgWrEn,
  input logic [1:0] cfgMode,
  input logic       cfgLowSwing,
  input logic       pipeN,
  input logic       sbValid,
  input logic       popEn,
  input logic       fifoEmpty,
  input logic       fifoFull,
  input logic [1:0] activeMode,
  input logic       modeLocked,
  input logic       protoErr,
  input logic       overflow,
  input logic       cfgErr
);

  AST_IDLE_NO_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    (activeMode == 2'd0 && fifoEmpty) |=> fifoEmpty); // R1
  AST_SELECT_SB: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !modeLocked && cfgMode == 2'd2) |=> (modeLocked && activeMode == 2'd2)); // R2
  AST_LOWSWING_REFUSE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !modeLocked && cfgLowSwing && cfgMode == 2'd1) |=> (!modeLocked && cfgErr)); // R3
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    modeLocked |=> (modeLocked && $stable(activeMode))); // R4
  AST_LATE_CFG_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (modeLocked && cfgWrEn) |=> cfgErr); // R4
  AST_STROBE_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    (activeMode == 2'd1 && !pipeN && !fifoFull) |=> !fifoEmpty); // R5
  AST_STROBE_MISUSE: assert property (@(posedge clk) disable iff (!rstN)
    (activeMode != 2'd1 && !pipeN) |=> protoErr); // R6
  AST_SB_MISUSE: assert property (@(posedge clk) disable iff (!rstN)
    (activeMode != 2'd2 && sbValid) |=> protoErr); // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoFull && fifoEmpty)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && !popEn && activeMode == 2'd1 && !pipeN) |=> (fifoFull && overflow)); // R10
  AST_STICKY_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (protoErr || overflow || cfgErr) |=>
      ((protoErr || !$past(protoErr)) && (overflow || !$past(overflow)) &&
       (cfgErr || !$past(cfgErr)))); // R11

endmodule

bind gfx_req_intake gri_checker i_gri_checker (
  .clk         (clk),
  .rstN        (rstN),
  .cfgWrEn     (cfgWrEn),
  .cfgMode     (cfgMode),
  .cfgLowSwing (cfgLowSwing),
  .pipeN       (pipeN),
  .sbValid     (sbValid),
  .popEn       (popEn),
  .fifoEmpty   (fifoEmpty),
  .fifoFull    (fifoFull),
  .activeMode  (activeMode),
  .modeLocked  (modeLocked),
  .protoErr    (protoErr),
  .overflow    (overflow),
  .cfgErr      (cfgErr)
);

// File: tb/test_gfx_req_intake.sv
module test_gfx_req_intake;

  localparam int AW    = 32;
  localparam int DEPTH = 8;
  localparam int BYTES = AW / 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWrEn = 1'b0;
  logic [1:0]    cfgMode = 2'd0;
  logic          cfgLowSwing = 1'b0;
  logic          pipeN = 1'b1;
  logic [AW-1:0] addrBus = '0;
  logic          sbValid = 1'b0;
  logic [7:0]    sbData = '0;
  logic          popEn = 1'b0;
  logic [AW-1:0] popData;
  logic          fifoEmpty, fifoFull, modeLocked, protoErr, overflow, cfgErr;
  logic [1:0]    activeMode;

  always #5 clk = ~clk;

  gfx_req_intake #(.ADDR_W(AW), .FIFO_DEPTH(DEPTH)) i_gfx_req_intake (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgMode(cfgMode),
    .cfgLowSwing(cfgLowSwing), .pipeN(pipeN), .addrBus(addrBus),
    .sbValid(sbValid), .sbData(sbData), .popEn(popEn), .popData(popData),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .activeMode(activeMode),
    .modeLocked(modeLocked), .protoErr(protoErr), .overflow(overflow),
    .cfgErr(cfgErr)
  );

  int    checks = 0;
  int    failures = 0;
  string tag = "R1";
  bit    done = 0;

  // Reference model state
  int            mMode;
  bit            mLocked, mProto, mOvf, mCfgErr;
  logic [AW-1:0] mQ[$];
  logic [AW-1:0] mAsm;
  int            mIdx;

  task automatic chk(string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mMode = 0; mLocked = 0; mProto = 0; mOvf = 0; mCfgErr = 0;
    mQ.delete(); mAsm = '0; mIdx = 0;
  endtask

  task automatic modelEdge();
    int            oldMode = mMode;
    bit            fullBefore = (mQ.size() == DEPTH);
    bit            doPush = 0;
    logic [AW-1:0] pushVal = '0;
    if (cfgWrEn) begin
      if (!mLocked && (cfgMode == 2 || (cfgMode == 1 && !cfgLowSwing))) begin
        mMode = cfgMode; mLocked = 1;
      end else mCfgErr = 1;
    end
    if (!pipeN) begin
      if (oldMode == 1) begin doPush = 1; pushVal = addrBus; end
      else mProto = 1;
    end
    if (sbValid) begin
      if (oldMode == 2) begin
        mAsm[mIdx*8 +: 8] = sbData;
        if (mIdx == BYTES - 1) begin doPush = 1; pushVal = mAsm; mIdx = 0; end
        else mIdx++;
      end else mProto = 1;
    end
    if (popEn && mQ.size() > 0) void'(mQ.pop_front());
    if (doPush) begin
      if (fullBefore) mOvf = 1;
      else mQ.push_back(pushVal);
    end
  endtask

  task automatic compare();
    chk("fifoEmpty", AW'(fifoEmpty), AW'(mQ.size() == 0));
    chk("fifoFull", AW'(fifoFull), AW'(mQ.size() == DEPTH));
    chk("activeMode", AW'(activeMode), AW'(mMode));
    chk("modeLocked", AW'(modeLocked), AW'(mLocked));
    chk("protoErr", AW'(protoErr), AW'(mProto));
    chk("overflow", AW'(overflow), AW'(mOvf));
    chk("cfgErr", AW'(cfgErr), AW'(mCfgErr));
    if (mQ.size() > 0) chk("popData", popData, mQ[0]);
  endtask

  task automatic step();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compare();
    cfgWrEn = 0; pipeN = 1; sbValid = 0; popEn = 0;
  endtask

  task automatic doReset();
    rstN = 0;
    modelReset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    compare();
    rstN = 1;
    @(negedge clk);
    compare();
  endtask

  task automatic cfg(input logic [1:0] m, input logic low);
    cfgWrEn = 1; cfgMode = m; cfgLowSwing = low; step();
  endtask

  task automatic strobe(input logic [AW-1:0] a, input logic pop);
    pipeN = 0; addrBus = a; popEn = pop; step();
  endtask

  task automatic sbByte(input logic [7:0] b, input logic pop);
    sbValid = 1; sbData = b; popEn = pop; step();
  endtask

  task automatic popOne();
    popEn = 1; step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    doReset();
    idle(2);
    // R1: no path selected, traffic on both buses is refused
    pipeN = 0; addrBus = 32'h1111_0000; step();
    sbByte(8'h55, 0);
    idle(1);

    tag = "R2"; doReset();
    cfg(2'd0, 0);          // R2: code 0 refused
    cfg(2'd3, 0);          // R2: code 3 refused
    idle(1);

    tag = "R3"; doReset();
    cfg(2'd1, 1);          // R3: strobe path under low swing refused
    idle(1);
    tag = "R2";
    cfg(2'd2, 1);          // R2: sideband allowed under low swing
    idle(1);

    tag = "R5"; doReset();
    cfg(2'd1, 0);
    strobe(32'hA000_0001, 0);
    strobe(32'hA000_0002, 0);
    strobe(32'hA000_0003, 0);
    idle(2);               // R5: strobe high pushes nothing
    strobe(32'hA000_0004, 1);

    tag = "R4";
    cfg(2'd2, 0);          // R4: late write ignored
    tag = "R8";
    sbByte(8'hEE, 0);      // R8: sideband in strobe mode
    sbByte(8'hDD, 0);

    tag = "R9";
    for (int i = 0; i < 6; i++) popOne();   // R9: drain plus pops on empty

    tag = "R10";
    for (int i = 0; i < DEPTH + 2; i++) strobe(32'hB000_0000 + i, 0);
    strobe(32'hBEEF_0000, 1);               // R10: push+pop on full, push dropped
    strobe(32'hBEEF_0001, 0);
    tag = "R11";
    idle(2);                                 // R11: flags stay set
    tag = "R9";
    for (int i = 0; i < DEPTH + 1; i++) popOne();

    tag = "R7"; doReset();
    cfg(2'd2, 0);
    sbByte(8'hD4, 0); sbByte(8'hC3, 0); sbByte(8'hB2, 0); sbByte(8'hA1, 0);
    sbByte(8'h01, 0); idle(2);
    sbByte(8'h02, 0); idle(1);
    tag = "R6";
    strobe(32'hCAFE_CAFE, 0);               // R6: strobe in sideband mode
    tag = "R7";
    sbByte(8'h03, 1); sbByte(8'h04, 0);
    for (int i = 0; i < 3 * BYTES; i++) sbByte(8'(8'h40 + i), (i % 5) == 0);
    tag = "R9";
    for (int i = 0; i < 6; i++) popOne();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule